// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

This block keeps a small set of in-flight store entries and answers byte-level forwarding queries from a two-stage load pipeline. Each entry tracks a physical address, a virtual address, a 16-lane byte-enable and 16 data bytes. It also carries three flags: allocated, address known and data known. Stores go through plain write ports: allocate, resolve address, supply data and free. Address resolution takes two clock edges to land in the entry.

A load presents its virtual and physical addresses, a byte mask, a vector marking which entries are older than it, and a tail index. The tail is the entry just younger than the youngest older store, and it only sets the search order. In the same cycle the unit returns a fast forward mask and a fast data-not-ready flag. One cycle later a registered result follows. It carries the forward mask, the forwarded bytes, a data-not-ready flag with the index of the store concerned, an address-unknown flag with its index, and a flag raised when the physical and virtual match vectors disagree. The requester replays the load on either wait flag and flushes the store entries on a disagreement.

The query path is a fixed-latency pipeline and takes no back-pressure. There is no ready signal, a query is accepted in every cycle that `q_valid` is high, and the stage-2 result appears exactly one cycle later whatever follows. The entry count must be a power of two, because the search order wraps modulo the entry count.

Top module: `stlf_unit`

## Requirements
- R1: While reset is asserted, and after it, no entry is allocated and `r2_valid` is 0. A query before any store activity forwards nothing and raises no flag.
- R2: For a requested lane b (`q_mask[b]`=1), `f1_mask[b]` is 1 in the query cycle when the selected store for that lane has data. `r2_mask` equals that mask one cycle later. Byte b of `r2_data` (bits 8b+7..8b) is the selected store's byte b, and it is zero for lanes that are not forwarded.
- R3: When several matching older stores write the same lane, the youngest supplies it. Youth is searched from entry `q_tail`-1 downward, wrapping modulo the entry count.
- R4: An entry takes part only if it is allocated, its address is known, its bit in `q_older` is 1, its address bits above bit 3 equal the load's, and its byte mask overlaps the load mask. Stores in another 16-byte line never forward.
- R5: If a lane's selected store has no data yet, that lane is not forwarded and `f1_data_wait` rises in the query cycle. One cycle later `r2_data_wait` is 1 and `r2_data_idx` holds the youngest such store. With no flag raised, the index reads 0.
- R6: Any allocated older entry whose address is unknown raises `r2_addr_wait` one cycle after the query. `r2_addr_idx` holds the youngest such entry, and reads 0 with no flag.
- R7: `r2_mismatch` is 1 one cycle after a query when the set of entries matching by virtual address differs from the set matching by physical address.
- R8: An address write takes effect on the second rising edge after it is presented. A query between the two edges still sees the entry's address as unknown.
- R9: Allocation marks an entry valid with both address and data unknown. Freeing removes the entry from all matching.
- R10: `r2_valid` follows `q_valid` by one cycle, and every other stage-2 output is zero when `r2_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate entry `alloc_idx` |
| alloc_idx | input | log2(N) | Entry to allocate |
| addr_valid | input | 1 | Address resolution for entry `addr_idx` |
| addr_idx | input | log2(N) | Entry receiving the address |
| addr_pa | input | PA_W | Store physical address |
| addr_va | input | VA_W | Store virtual address |
| addr_mask | input | BYTES | Store byte-enable, bit b = lane b |
| data_valid | input | 1 | Data write for entry `data_idx` |
| data_idx | input | log2(N) | Entry receiving data |
| data_bytes | input | 8*BYTES | Store data, lane b in bits 8b+7..8b |
| free_valid | input | 1 | Free entry `free_idx` |
| free_idx | input | log2(N) | Entry to free |
| q_valid | input | 1 | Load query present |
| q_pa | input | PA_W | Load physical address |
| q_va | input | VA_W | Load virtual address |
| q_mask | input | BYTES | Load byte mask |
| q_older | input | N | One-hot-decoded set of entries older than the load |
| q_tail | input | log2(N) | Entry just younger than the youngest older store |
| f1_mask | output | BYTES | Fast forward mask, query cycle |
| f1_data_wait | output | 1 | Fast data-not-ready, query cycle |
| r2_valid | output | 1 | Stage-2 result present |
| r2_mask | output | BYTES | Stage-2 forward mask |
| r2_data | output | 8*BYTES | Stage-2 forwarded bytes |
| r2_data_wait | output | 1 | Selected store has no data yet |
| r2_data_idx | output | log2(N) | Youngest such store |
| r2_addr_wait | output | 1 | Older store with unknown address |
| r2_addr_idx | output | log2(N) | Youngest such store |
| r2_mismatch | output | 1 | Physical and virtual match vectors differ |

## Verification
The assertions hold on every cycle for the pipeline relations. The stage-2 valid tracks the query valid. Stage-2 outputs are quiet when idle. The stage-2 mask and wait flag copy the fast values from the cycle before. The fast mask stays inside the load mask, and a load with no older entries forwards nothing. Youngest-wins selection, the line and overlap rule, the wait indices, the mismatch detection, the two-edge address landing and the effect of allocate and free all depend on stored contents. Only the bench can show them. It sweeps every tail position and every older vector against a populated buffer, then runs directed allocate, address and free sequences.

// File: rtl/stlf_pkg.sv
package stlf_pkg;
  localparam int LANE_W = 8;
  typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/stlf_store.sv
module stlf_store #(
  parameter int N     = 8,
  parameter int BYTES = 16,
  parameter int PA_W  = 32,
  parameter int VA_W  = 39,
  localparam int IW   = $clog2(N),
  localparam int DW   = BYTES * stlf_pkg::LANE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_valid,
  input  logic [IW-1:0]               alloc_idx,
  input  logic                        addr_valid,
  input  logic [IW-1:0]               addr_idx,
  input  logic [PA_W-1:0]             addr_pa,
  input  logic [VA_W-1:0]             addr_va,
  input  logic [BYTES-1:0]            addr_mask,
  input  logic                        data_valid,
  input  logic [IW-1:0]               data_idx,
  input  logic [DW-1:0]               data_bytes,
  input  logic                        free_valid,
  input  logic [IW-1:0]               free_idx,
  output logic [N-1:0]                e_valid,
  output logic [N-1:0]                e_aok,
  output logic [N-1:0]                e_dok,
  output logic [N-1:0][PA_W-1:0]      e_pa,
  output logic [N-1:0][VA_W-1:0]      e_va,
  output logic [N-1:0][BYTES-1:0]     e_mask,
  output logic [N-1:0][DW-1:0]        e_data
);
  // address resolution is staged one cycle before it lands in the entry
  logic             st_v;
  logic [IW-1:0]    st_idx;
  logic [PA_W-1:0]  st_pa;
  logic [VA_W-1:0]  st_va;
  logic [BYTES-1:0] st_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v    <= 1'b0;
      st_idx  <= '0;
      st_pa   <= '0;
      st_va   <= '0;
      st_mask <= '0;
    end else begin
      st_v    <= addr_valid;
      st_idx  <= addr_idx;
      st_pa   <= addr_pa;
      st_va   <= addr_va;
      st_mask <= addr_mask;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_valid[i] <= 1'b0;
        e_aok[i]   <= 1'b0;
        e_dok[i]   <= 1'b0;
        e_pa[i]    <= '0;
        e_va[i]    <= '0;
        e_mask[i]  <= '0;
        e_data[i]  <= '0;
      end else begin
        if (st_v && st_idx == IW'(i)) begin
          e_pa[i]   <= st_pa;
          e_va[i]   <= st_va;
          e_mask[i] <= st_mask;
          e_aok[i]  <= 1'b1;
        end
        if (data_valid && data_idx == IW'(i)) begin
          e_data[i] <= data_bytes;
          e_dok[i]  <= 1'b1;
        end
        if (alloc_valid && alloc_idx == IW'(i)) begin
          e_valid[i] <= 1'b1;
          e_aok[i]   <= 1'b0;
          e_dok[i]   <= 1'b0;
        end
        if (free_valid && free_idx == IW'(i)) begin
          e_valid[i] <= 1'b0;
          e_aok[i]   <= 1'b0;
          e_dok[i]   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/stlf_match.sv
module stlf_match #(
  parameter int N     = 8,
  parameter int BYTES = 16,
  parameter int AW    = 32,
  localparam int LSB  = $clog2(BYTES)
) (
  input  logic [AW-1:0]           q_addr,
  input  logic [BYTES-1:0]        q_mask,
  input  logic [N-1:0]            q_older,
  input  logic [N-1:0]            e_valid,
  input  logic [N-1:0]            e_aok,
  input  logic [N-1:0][AW-1:0]    e_addr,
  input  logic [N-1:0][BYTES-1:0] e_mask,
  output logic [N-1:0]            hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = e_valid[i] && e_aok[i] && q_older[i]
                 && ((e_addr[i] >> LSB) == (q_addr >> LSB))
                 && |(e_mask[i] & q_mask);
  end
endmodule

// File: rtl/stlf_pick.sv
module stlf_pick #(
  parameter int N    = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] tail,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    logic [IW-1:0] cand;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      cand = tail - IW'(k + 1);
      if (!found && vec[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/stlf_select.sv
module stlf_select #(
  parameter int N     = 8,
  parameter int BYTES = 16,
  localparam int IW   = $clog2(N),
  localparam int LW   = stlf_pkg::LANE_W,
  localparam int DW   = BYTES * LW
) (
  input  logic [N-1:0]            hit,
  input  logic [N-1:0][BYTES-1:0] e_mask,
  input  logic [N-1:0]            e_dok,
  input  logic [N-1:0][DW-1:0]    e_data,
  input  logic [IW-1:0]           tail,
  input  logic [BYTES-1:0]        q_mask,
  output logic [BYTES-1:0]        fmask,
  output logic [DW-1:0]           fdata,
  output logic [N-1:0]            wait_vec
);
  logic [BYTES-1:0]         lane_hit;
  logic [BYTES-1:0][IW-1:0] lane_sel;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [N-1:0]  writers;
    logic          fnd;
    logic [IW-1:0] sel;
    stlf_pkg::lane_t bval;
    for (genvar i = 0; i < N; i++) begin : g_w
      assign writers[i] = hit[i] && e_mask[i][b] && q_mask[b];
    end
    stlf_pick #(.N(N)) u_pick (.vec(writers), .tail(tail), .found(fnd), .idx(sel));
    assign bval        = e_data[sel][b*LW +: LW];
    assign lane_hit[b] = fnd;
    assign lane_sel[b] = sel;
    assign fmask[b]    = fnd && e_dok[sel];
    assign fdata[b*LW +: LW] = fmask[b] ? bval : '0;
  end

  always_comb begin
    wait_vec = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (lane_hit[b] && !e_dok[lane_sel[b]]) wait_vec[lane_sel[b]] = 1'b1;
    end
  end
endmodule

// File: rtl/stlf_unit.sv
module stlf_unit #(
  parameter int N     = 8,
  parameter int BYTES = 16,
  parameter int PA_W  = 32,
  parameter int VA_W  = 39,
  localparam int IW   = $clog2(N),
  localparam int DW   = BYTES * stlf_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [IW-1:0]    alloc_idx,
  input  logic             addr_valid,
  input  logic [IW-1:0]    addr_idx,
  input  logic [PA_W-1:0]  addr_pa,
  input  logic [VA_W-1:0]  addr_va,
  input  logic [BYTES-1:0] addr_mask,
  input  logic             data_valid,
  input  logic [IW-1:0]    data_idx,
  input  logic [DW-1:0]    data_bytes,
  input  logic             free_valid,
  input  logic [IW-1:0]    free_idx,
  input  logic             q_valid,
  input  logic [PA_W-1:0]  q_pa,
  input  logic [VA_W-1:0]  q_va,
  input  logic [BYTES-1:0] q_mask,
  input  logic [N-1:0]     q_older,
  input  logic [IW-1:0]    q_tail,
  output logic [BYTES-1:0] f1_mask,
  output logic             f1_data_wait,
  output logic             r2_valid,
  output logic [BYTES-1:0] r2_mask,
  output logic [DW-1:0]    r2_data,
  output logic             r2_data_wait,
  output logic [IW-1:0]    r2_data_idx,
  output logic             r2_addr_wait,
  output logic [IW-1:0]    r2_addr_idx,
  output logic             r2_mismatch
);
  logic [N-1:0]            e_valid, e_aok, e_dok;
  logic [N-1:0][PA_W-1:0]  e_pa;
  logic [N-1:0][VA_W-1:0]  e_va;
  logic [N-1:0][BYTES-1:0] e_mask;
  logic [N-1:0][DW-1:0]    e_data;

  stlf_store #(.N(N), .BYTES(BYTES), .PA_W(PA_W), .VA_W(VA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_pa(addr_pa),
    .addr_va(addr_va), .addr_mask(addr_mask),
    .data_valid(data_valid), .data_idx(data_idx), .data_bytes(data_bytes),
    .free_valid(free_valid), .free_idx(free_idx),
    .e_valid(e_valid), .e_aok(e_aok), .e_dok(e_dok),
    .e_pa(e_pa), .e_va(e_va), .e_mask(e_mask), .e_data(e_data)
  );

  logic [N-1:0] vhit, phit;

  stlf_match #(.N(N), .BYTES(BYTES), .AW(VA_W)) u_vmatch (
    .q_addr(q_va), .q_mask(q_mask), .q_older(q_older), .e_valid(e_valid),
    .e_aok(e_aok), .e_addr(e_va), .e_mask(e_mask), .hit(vhit)
  );
  stlf_match #(.N(N), .BYTES(BYTES), .AW(PA_W)) u_pmatch (
    .q_addr(q_pa), .q_mask(q_mask), .q_older(q_older), .e_valid(e_valid),
    .e_aok(e_aok), .e_addr(e_pa), .e_mask(e_mask), .hit(phit)
  );

  logic [BYTES-1:0] fmask;
  logic [DW-1:0]    fdata;
  logic [N-1:0]     wait_vec;

  stlf_select #(.N(N), .BYTES(BYTES)) u_sel (
    .hit(vhit), .e_mask(e_mask), .e_dok(e_dok), .e_data(e_data),
    .tail(q_tail), .q_mask(q_mask), .fmask(fmask), .fdata(fdata), .wait_vec(wait_vec)
  );

  logic [N-1:0]  unk_vec;
  logic          dw_fnd, aw_fnd;
  logic [IW-1:0] dw_idx, aw_idx;

  assign unk_vec = e_valid & ~e_aok & q_older;

  stlf_pick #(.N(N)) u_dpick (.vec(wait_vec), .tail(q_tail), .found(dw_fnd), .idx(dw_idx));
  stlf_pick #(.N(N)) u_apick (.vec(unk_vec),  .tail(q_tail), .found(aw_fnd), .idx(aw_idx));

  assign f1_mask      = q_valid ? fmask : '0;
  assign f1_data_wait = q_valid && dw_fnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r2_valid     <= 1'b0;
      r2_mask      <= '0;
      r2_data      <= '0;
      r2_data_wait <= 1'b0;
      r2_data_idx  <= '0;
      r2_addr_wait <= 1'b0;
      r2_addr_idx  <= '0;
      r2_mismatch  <= 1'b0;
    end else begin
      r2_valid     <= q_valid;
      r2_mask      <= f1_mask;
      r2_data      <= q_valid ? fdata : '0;
      r2_data_wait <= f1_data_wait;
      r2_data_idx  <= q_valid ? dw_idx : '0;
      r2_addr_wait <= q_valid && aw_fnd;
      r2_addr_idx  <= q_valid ? aw_idx : '0;
      r2_mismatch  <= q_valid && (vhit != phit);
    end
  end
endmodule

// File: rtl/stlf_unit_chk.sv
module stlf_unit_chk #(
  parameter int N     = 8,
  parameter int BYTES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q_valid,
  input logic [BYTES-1:0] q_mask,
  input logic [N-1:0]     q_older,
  input logic [BYTES-1:0] f1_mask,
  input logic             f1_data_wait,
  input logic             r2_valid,
  input logic [BYTES-1:0] r2_mask,
  input logic             r2_data_wait,
  input logic             r2_addr_wait,
  input logic             r2_mismatch
);
  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !r2_valid);

  assert_stage_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> r2_valid);

  assert_stage_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> (!r2_valid && r2_mask == '0 && !r2_data_wait && !r2_addr_wait && !r2_mismatch));

  assert_fast_to_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> r2_mask == $past(f1_mask));

  assert_lane_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> (f1_mask & ~q_mask) == '0);

  assert_wait_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> r2_data_wait == $past(f1_data_wait));

  assert_no_older_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_older == '0) |-> (f1_mask == '0 && !f1_data_wait));
endmodule

bind stlf_unit stlf_unit_chk #(.N(N), .BYTES(BYTES)) u_chk (.*);

// File: tb/test_stlf_unit.sv
module test_stlf_unit;
  localparam int N  = 8;
  localparam int B  = 16;
  localparam int PW = 16;
  localparam int VW = 16;
  localparam int IW = 3;
  localparam int DW = B * 8;
  localparam logic [PW-1:0] QPA = 16'h8A35;
  localparam logic [VW-1:0] QVA = 16'h1235;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, addr_valid = 0, data_valid = 0, free_valid = 0, q_valid = 0;
  logic [IW-1:0] alloc_idx = '0, addr_idx = '0, data_idx = '0, free_idx = '0, q_tail = '0;
  logic [PW-1:0] addr_pa = '0, q_pa = '0;
  logic [VW-1:0] addr_va = '0, q_va = '0;
  logic [B-1:0]  addr_mask = '0, q_mask = '0;
  logic [DW-1:0] data_bytes = '0;
  logic [N-1:0]  q_older = '0;
  logic [B-1:0]  f1_mask, r2_mask;
  logic          f1_data_wait, r2_valid, r2_data_wait, r2_addr_wait, r2_mismatch;
  logic [DW-1:0] r2_data;
  logic [IW-1:0] r2_data_idx, r2_addr_idx;

  always #5 clk = ~clk;

  stlf_unit #(.N(N), .BYTES(B), .PA_W(PW), .VA_W(VW)) i_stlf_unit (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_pa(addr_pa),
    .addr_va(addr_va), .addr_mask(addr_mask),
    .data_valid(data_valid), .data_idx(data_idx), .data_bytes(data_bytes),
    .free_valid(free_valid), .free_idx(free_idx),
    .q_valid(q_valid), .q_pa(q_pa), .q_va(q_va), .q_mask(q_mask),
    .q_older(q_older), .q_tail(q_tail),
    .f1_mask(f1_mask), .f1_data_wait(f1_data_wait),
    .r2_valid(r2_valid), .r2_mask(r2_mask), .r2_data(r2_data),
    .r2_data_wait(r2_data_wait), .r2_data_idx(r2_data_idx),
    .r2_addr_wait(r2_addr_wait), .r2_addr_idx(r2_addr_idx), .r2_mismatch(r2_mismatch)
  );

  int tests = 0;
  int fails = 0;

  // bench-side picture of the store entries
  logic [N-1:0]  m_v = '0, m_aok = '0, m_dok = '0;
  logic [PW-1:0] m_pa [N];
  logic [VW-1:0] m_va [N];
  logic [B-1:0]  m_mask [N];
  logic [DW-1:0] m_data [N];

  logic [B-1:0]  exp_mask;
  logic [DW-1:0] exp_data;
  logic          exp_dw, exp_aw, exp_mm;
  logic [IW-1:0] exp_didx, exp_aidx;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [IW-1:0] tl, input logic [N-1:0] old, input logic [B-1:0] qm);
    logic [N-1:0] vm, pm, wv, unk;
    logic found;
    logic [IW-1:0] sel, c;
    vm = '0; pm = '0; wv = '0;
    for (int i = 0; i < N; i++) begin
      logic base;
      base  = m_v[i] && m_aok[i] && old[i] && ((m_mask[i] & qm) != '0);
      vm[i] = base && (m_va[i][VW-1:4] == QVA[VW-1:4]);
      pm[i] = base && (m_pa[i][PW-1:4] == QPA[PW-1:4]);
    end
    exp_mask = '0; exp_data = '0;
    for (int b = 0; b < B; b++) begin
      found = 0; sel = '0;
      for (int k = 1; k <= N; k++) begin
        c = tl - IW'(k);
        if (!found && qm[b] && vm[c] && m_mask[c][b]) begin found = 1; sel = c; end
      end
      if (found) begin
        if (m_dok[sel]) begin
          exp_mask[b] = 1'b1;
          exp_data[b*8 +: 8] = m_data[sel][b*8 +: 8];
        end else wv[sel] = 1'b1;
      end
    end
    unk = m_v & ~m_aok & old;
    exp_dw = 0; exp_didx = '0; exp_aw = 0; exp_aidx = '0;
    for (int k = 1; k <= N; k++) begin
      c = tl - IW'(k);
      if (!exp_dw && wv[c])  begin exp_dw = 1; exp_didx = c; end
      if (!exp_aw && unk[c]) begin exp_aw = 1; exp_aidx = c; end
    end
    exp_mm = (vm != pm);
  endtask

  task automatic query(input logic [IW-1:0] tl, input logic [N-1:0] old, input logic [B-1:0] qm);
    q_valid = 1; q_tail = tl; q_older = old; q_mask = qm; q_pa = QPA; q_va = QVA;
    #1;
    model(tl, old, qm);
    chk("R2 fast mask", f1_mask, exp_mask);
    chk("R5 fast data wait", f1_data_wait, exp_dw);
    @(negedge clk);
    chk("R10 stage2 valid", r2_valid, 1);
    chk("R2 stage2 mask", r2_mask, exp_mask);
    chk("R3 stage2 data youngest", r2_data, exp_data);
    chk("R5 data wait+idx", {r2_data_wait, r2_data_idx}, {exp_dw, exp_didx});
    chk("R6 addr wait+idx", {r2_addr_wait, r2_addr_idx}, {exp_aw, exp_aidx});
    chk("R7 mismatch", r2_mismatch, exp_mm);
  endtask

  task automatic do_alloc(input int i);
    alloc_valid = 1; alloc_idx = IW'(i);
    @(negedge clk); alloc_valid = 0;
    m_v[i] = 1; m_aok[i] = 0; m_dok[i] = 0;
  endtask

  task automatic do_addr(input int i, input logic [PW-1:0] pa, input logic [VW-1:0] va, input logic [B-1:0] mk);
    addr_valid = 1; addr_idx = IW'(i); addr_pa = pa; addr_va = va; addr_mask = mk;
    @(negedge clk); addr_valid = 0;
    @(negedge clk);
    m_aok[i] = 1; m_pa[i] = pa; m_va[i] = va; m_mask[i] = mk;
  endtask

  task automatic do_data(input int i);
    logic [DW-1:0] d;
    for (int b = 0; b < B; b++) d[b*8 +: 8] = 8'(i * 16 + b);
    data_valid = 1; data_idx = IW'(i); data_bytes = d;
    @(negedge clk); data_valid = 0;
    m_dok[i] = 1; m_data[i] = d;
  endtask

  task automatic do_free(input int i);
    free_valid = 1; free_idx = IW'(i);
    @(negedge clk); free_valid = 0;
    m_v[i] = 0; m_aok[i] = 0; m_dok[i] = 0;
  endtask

  function automatic logic [B-1:0] ent_mask(input int i);
    case (i)
      0: return 16'hFFFF; 1: return 16'h00FF; 2: return 16'h0F00; 3: return 16'hF000;
      4: return 16'h000F; 5: return 16'hFFFF; 6: return 16'h3C3C; default: return 16'h0FF0;
    endcase
  endfunction

  function automatic logic [B-1:0] load_mask(input int j);
    case (j)
      0: return 16'hFFFF; 1: return 16'h00F0; 2: return 16'h0F0F; default: return 16'h8001;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      m_pa[i] = '0; m_va[i] = '0; m_mask[i] = '0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset valid", r2_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", r2_valid, 0);
    query(3'd0, 8'hFF, 16'hFFFF);
    chk("R1 empty no forward", {r2_mask, r2_addr_wait, r2_data_wait}, 0);

    for (int i = 0; i < N; i++) do_alloc(i);
    for (int i = 0; i < N; i++)
      if (i != 6)
        do_addr(i, (i == 2) ? 16'h9930 : 16'h8A30, (i == 5) ? 16'h1240 : 16'h1230, ent_mask(i));
    for (int i = 0; i < N; i++) if (i != 3) do_data(i);

    for (int tl = 0; tl < N; tl++)
      for (int old = 0; old < 256; old++)
        for (int j = 0; j < 4; j++)
          query(IW'(tl), N'(old), load_mask(j));
    q_valid = 0;
    @(negedge clk);
    chk("R10 idle stage2", {r2_valid, r2_mask, r2_mismatch}, 0);

    query(3'd0, 8'b0010_0000, 16'hFFFF);
    chk("R4 other line ignored", r2_mask, 0);
    query(3'd0, 8'h00, 16'hFFFF);
    chk("R4 none older", {r2_mask, r2_data_wait}, 0);

    do_free(3);
    query(3'd0, 8'hFF, 16'hFFFF);
    chk("R9 freed store drops out", r2_data_wait, 0);
    do_free(7);
    do_alloc(7);
    query(3'd0, 8'h80, 16'hFFFF);
    chk("R9 alloc address unknown", {r2_addr_wait, r2_addr_idx}, {1'b1, 3'd7});

    addr_valid = 1; addr_idx = 3'd7; addr_pa = 16'h8A30; addr_va = 16'h1230; addr_mask = 16'h00F0;
    @(negedge clk); addr_valid = 0;
    query(3'd0, 8'h80, 16'h00F0);
    chk("R8 first edge still unknown", r2_addr_wait, 1);
    m_aok[7] = 1; m_pa[7] = 16'h8A30; m_va[7] = 16'h1230; m_mask[7] = 16'h00F0;
    query(3'd0, 8'h80, 16'h00F0);
    chk("R8 visible after second edge", {r2_addr_wait, r2_data_wait, r2_data_idx}, {1'b0, 1'b1, 3'd7});
    do_data(7);
    query(3'd0, 8'h80, 16'h00F0);
    chk("R8 forwards once data lands", r2_mask, 16'h00F0);
    q_valid = 0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule